// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block is the address-recognition stage of an I2C slave. Software programs four 8-bit slot registers. In each slot the upper seven bits hold a slave address and the lowest bit allows the general-call address to be answered through that slot. After every START or repeated START, the bit-level front end hands over the first received byte. The matcher compares that byte against all four slots in parallel.

The matcher returns a registered verdict one clock after the byte arrives, so the front end can pull SDA low during the ninth SCL period. The verdict has four parts: whether to acknowledge, which slot matched, whether the match came through general call, and the read/write direction. The verdict stays latched until the next START or STOP. Slots can be read and written at any time, but they are only used while slave mode is enabled.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset all four slots read as 0x00, and `ack_o`, `gc_o`, `idx_o`, `rnw_o` and `dec_valid_o` are 0, so no address is acknowledged.
- R2: A write to slot `reg_sel_i` with `reg_we_i` high is visible on `reg_rdata_o` from the next cycle on. This holds whether `slave_en_i` is high or low.
- R3: A slot matches normally when its bits 7:1 are nonzero and equal bits 7:1 of the first byte. The verdict then has `ack_o`=1 and `gc_o`=0.
- R4: When bits 7:1 of the first byte are zero, a slot with bit 0 set matches as general call. The verdict then has `ack_o`=1 and `gc_o`=1.
- R5: A slot holding 0x00 never matches. A first byte that matches no slot gives `ack_o`=0, `gc_o`=0 and `idx_o`=0.
- R6: When several slots match, `idx_o` reports the lowest-numbered matching slot, and `gc_o` follows that slot's kind of match.
- R7: `rnw_o` takes bit 0 of the first byte after a START (1 = read).
- R8: Only the first byte after a START or repeated START is evaluated. Later bytes leave every verdict output unchanged and raise no `dec_valid_o`.
- R9: With `slave_en_i` low when the first byte arrives, `ack_o` and `gc_o` stay 0.
- R10: The verdict outputs change exactly one cycle after the first byte and hold until `start_i` or `stop_i`. Either of these clears them on the following cycle. A START or STOP in the same cycle as a byte takes priority over it.
- R11: `dec_valid_o` is a single-cycle pulse one clock after the first byte following a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_en_i | input | 1 | Slave mode enable |
| reg_we_i | input | 1 | Slot register write strobe |
| reg_sel_i | input | 2 | Slot register select |
| reg_wdata_i | input | 8 | Slot register write data |
| reg_rdata_o | output | 8 | Selected slot register contents |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| byte_valid_i | input | 1 | A received byte is on `byte_i` (pulse) |
| byte_i | input | 8 | Received byte |
| dec_valid_o | output | 1 | Address verdict produced (pulse) |
| ack_o | output | 1 | Acknowledge the address |
| gc_o | output | 1 | Match came through general call |
| idx_o | output | 2 | Matching slot index |
| rnw_o | output | 1 | Transfer direction, 1 = read |

## Verification
Every verdict output, including the `dec_valid_o` pulse, appears exactly one clock after the byte strobe. A START or STOP clears the verdict one clock after its pulse. A register write is visible on the read port one clock after the strobe. The bench drives inputs on falling edges and holds each strobe for one full cycle. It then checks on the next falling edge, which is the first point where the registered result is valid. It looks again one cycle later to confirm that pulses have dropped and latched values have held.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned SLOTS_DEF = 4;
  localparam int unsigned BYTE_W    = 8;

  typedef struct packed {
    logic ack;
    logic gc;
    logic rnw;
  } am_verdict_t;
endpackage

// File: rtl/am_slot_regs.sv
module am_slot_regs #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AW        = 8,
  localparam int unsigned IW       = $clog2(NUM_SLOTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IW-1:0]                 sel_i,
  input  logic [AW-1:0]                 wdata_i,
  output logic [AW-1:0]                 rdata_o,
  output logic [NUM_SLOTS-1:0][AW-1:0]  slots_o
);
  logic [NUM_SLOTS-1:0][AW-1:0] slot_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[g] <= '0;
      else if (we_i && sel_i == IW'(g))     slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[sel_i];
  assign slots_o = slot_q;
endmodule

// File: rtl/am_slot_cmp.sv
module am_slot_cmp #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] slot_i,
  input  logic [AW-2:0] addr_i,
  output logic          hit_norm_o,
  output logic          hit_gc_o
);
  // a slot of all zeros can match neither way
  assign hit_norm_o = (slot_i[AW-1:1] != '0) && (slot_i[AW-1:1] == addr_i);
  assign hit_gc_o   = slot_i[0] && (addr_i == '0);
endmodule

// File: rtl/am_prio_sel.sv
module am_prio_sel #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IW       = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] hit_norm_i,
  input  logic [NUM_SLOTS-1:0] hit_gc_i,
  output logic                 any_o,
  output logic                 gc_o,
  output logic [IW-1:0]        idx_o
);
  logic [NUM_SLOTS-1:0] hit;
  assign hit   = hit_norm_i | hit_gc_i;
  assign any_o = |hit;

  // descending scan: lowest index wins
  always_comb begin
    idx_o = '0;
    gc_o  = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        idx_o = IW'(i);
        gc_o  = hit_gc_i[i];
      end
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOTS_DEF,
  parameter int unsigned AW        = BYTE_W,
  localparam int unsigned IW       = $clog2(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_en_i,
  input  logic          reg_we_i,
  input  logic [IW-1:0] reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_valid_i,
  input  logic [AW-1:0] byte_i,
  output logic          dec_valid_o,
  output logic          ack_o,
  output logic          gc_o,
  output logic [IW-1:0] idx_o,
  output logic          rnw_o
);
  logic [NUM_SLOTS-1:0][AW-1:0] slots;
  logic [NUM_SLOTS-1:0]         hit_norm, hit_gc;
  logic                         any_hit, sel_gc;
  logic [IW-1:0]                sel_idx;
  logic                         armed_q, dec_q, first_byte, bus_evt;
  am_verdict_t                  verd_q, verd_d;
  logic [IW-1:0]                idx_q;

  am_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .slots_o (slots)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    am_slot_cmp #(.AW(AW)) u_cmp (
      .slot_i     (slots[g]),
      .addr_i     (byte_i[AW-1:1]),
      .hit_norm_o (hit_norm[g]),
      .hit_gc_o   (hit_gc[g])
    );
  end

  am_prio_sel #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .hit_norm_i (hit_norm),
    .hit_gc_i   (hit_gc),
    .any_o      (any_hit),
    .gc_o       (sel_gc),
    .idx_o      (sel_idx)
  );

  assign bus_evt    = start_i | stop_i;
  assign first_byte = byte_valid_i & armed_q & ~bus_evt;

  always_comb begin
    verd_d.ack = slave_en_i & any_hit;
    verd_d.gc  = slave_en_i & any_hit & sel_gc;
    verd_d.rnw = byte_i[0];
  end

  // armed from START until the first byte; STOP disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             armed_q <= 1'b0;
    else if (bus_evt)        armed_q <= start_i;
    else if (byte_valid_i)   armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= 1'b0;
      verd_q <= '0;
      idx_q  <= '0;
    end else begin
      dec_q <= first_byte;
      if (bus_evt) begin
        verd_q <= '0;
        idx_q  <= '0;
      end else if (first_byte) begin
        verd_q <= verd_d;
        idx_q  <= verd_d.ack ? sel_idx : '0;
      end
    end
  end

  assign dec_valid_o = dec_q;
  assign ack_o       = verd_q.ack;
  assign gc_o        = verd_q.gc;
  assign rnw_o       = verd_q.rnw;
  assign idx_o       = idx_q;
endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk #(
  parameter int unsigned IW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          slave_en_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          dec_valid_o,
  input logic          ack_o,
  input logic          gc_o,
  input logic [IW-1:0] idx_o,
  input logic          rnw_o
);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (!ack_o && !gc_o && idx_o == '0 && !rnw_o));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i) |=> (dec_valid_o || ($stable(ack_o) && $stable(gc_o)
                                && $stable(idx_o) && $stable(rnw_o))));

  a_r4_gc_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_o |-> ack_o);

  a_r5_idle_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (idx_o == '0 && !gc_o));

  a_r9_slave_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !$past(slave_en_i)) |-> !ack_o);

  a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slave_en_i  (slave_en_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .dec_valid_o (dec_valid_o),
  .ack_o       (ack_o),
  .gc_o        (gc_o),
  .idx_o       (idx_o),
  .rnw_o       (rnw_o)
);

// File: tb/i2c_addr_matcher_tb_top.sv
module i2c_addr_matcher_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slave_en_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       dec_valid_o, ack_o, gc_o, rnw_o;
  logic [1:0] idx_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_addr_matcher dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_verdict(input string req, input int ack, input int gc,
                               input int idx, input int rnw);
    check({req, " ack"}, int'(ack_o), ack);
    check({req, " gc"},  int'(gc_o),  gc);
    check({req, " idx"}, int'(idx_o), idx);
    check({req, " rnw"}, int'(rnw_o), rnw);
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = 2'(sel); reg_wdata_i = 8'(val);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  // leaves the bench at the negedge after the sampling edge
  task automatic send_byte(input int b);
    @(negedge clk_i); byte_valid_i = 1'b1; byte_i = 8'(b);
    @(negedge clk_i); byte_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      reg_sel_i = 2'(i); #1;
      check("R1 slot reset", int'(reg_rdata_o), 0);
    end
    check_verdict("R1 outputs reset", 0, 0, 0, 0);
    check("R1 dec reset", int'(dec_valid_o), 0);
    slave_en_i = 1'b1;
    pulse_start(); send_byte(8'h00);
    check("R1 nothing acked", int'(ack_o), 0);
    pulse_stop();
  endtask

  task automatic t_regs();
    slave_en_i = 1'b0;
    wr(0, 8'hA0); wr(1, 8'h31); wr(2, 8'hA0); wr(3, 8'h00);
    reg_sel_i = 2'd0; #1; check("R2 readback 0", int'(reg_rdata_o), 8'hA0);
    reg_sel_i = 2'd1; #1; check("R2 readback 1", int'(reg_rdata_o), 8'h31);
    reg_sel_i = 2'd2; #1; check("R2 readback 2", int'(reg_rdata_o), 8'hA0);
    reg_sel_i = 2'd3; #1; check("R2 readback 3", int'(reg_rdata_o), 8'h00);
    slave_en_i = 1'b1;
  endtask

  task automatic t_normal();
    pulse_start(); send_byte(8'h30);
    check("R11 dec pulse", int'(dec_valid_o), 1);
    check_verdict("R3 normal match", 1, 0, 1, 0);
    @(negedge clk_i);
    check("R11 dec drops", int'(dec_valid_o), 0);
    check_verdict("R10 held", 1, 0, 1, 0);
  endtask

  task automatic t_prio();
    pulse_start(); send_byte(8'hA1);
    check_verdict("R6 lowest slot", 1, 0, 0, 1);
    check("R7 read dir", int'(rnw_o), 1);
  endtask

  task automatic t_gc();
    pulse_start(); send_byte(8'h00);
    check_verdict("R4 general call", 1, 1, 1, 0);
  endtask

  task automatic t_nomatch();
    pulse_start(); send_byte(8'h44);
    check_verdict("R5 no match", 0, 0, 0, 0);
    wr(1, 8'h30);
    pulse_start(); send_byte(8'h00);
    check_verdict("R5 gc disabled", 0, 0, 0, 0);
    wr(1, 8'h31);
  endtask

  task automatic t_first_only();
    pulse_start(); send_byte(8'h30);
    check_verdict("R8 first byte", 1, 0, 1, 0);
    send_byte(8'h45);
    check("R8 no dec", int'(dec_valid_o), 0);
    check_verdict("R8 later byte ignored", 1, 0, 1, 0);
  endtask

  task automatic t_clear();
    pulse_stop();
    check_verdict("R10 stop clears", 0, 0, 0, 0);
    pulse_start(); send_byte(8'hA0);
    check_verdict("R10 rematch", 1, 0, 0, 0);
    pulse_start();
    check_verdict("R10 start clears", 0, 0, 0, 0);
    // start together with byte: start wins, byte not evaluated
    @(negedge clk_i); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h30;
    @(negedge clk_i); start_i = 1'b0; byte_valid_i = 1'b0;
    check("R10 start beats byte", int'(dec_valid_o), 0);
    check("R10 start beats byte ack", int'(ack_o), 0);
    send_byte(8'h30);
    check_verdict("R10 armed after start", 1, 0, 1, 0);
  endtask

  task automatic t_slave_off();
    slave_en_i = 1'b0;
    pulse_start(); send_byte(8'h00);
    check("R9 dec pulses", int'(dec_valid_o), 1);
    check_verdict("R9 no ack off", 0, 0, 0, 0);
    slave_en_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_normal();
    t_prio();
    t_gc();
    t_nomatch();
    t_first_only();
    t_clear();
    t_slave_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule